// File: doc/BRIEF.md
# Synchronized Rising-Edge Pulse Generator

This block takes a slow, asynchronous level, for example a push button or a switch that a person holds for any length of time, and produces a pulse exactly one clock cycle wide for every low-to-high change of that level. Downstream logic can then use the pulse as a one-shot enable, for example to advance a counter once per press.

The raw level first passes through a chain of back-to-back flip-flops, two by default, so that any metastable sample can settle before logic uses it. Only the last flop of that chain feeds the detector. A compile-time parameter picks one of two detectors. The state-only detector holds a two-bit state and drives the pulse from the state alone. The input-aware detector keeps a single bit holding the previous synchronized level, and its pulse appears one cycle earlier.

Reset is synchronous and active low. It clears the synchronizer and the detector state. Because of this, a level that is already high when reset is released is seen as a fresh rise.

Top module: `rise_pulse_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is sampled low, the pulse output is 0.
- R2: With the state-only detector (USE_MEALY=0), each rise of a level held high gives exactly one pulse, one cycle wide. The pulse is visible after the third rising clock edge that follows the change of the raw input. The state register takes only the codes 00 (idle), 01 (rise seen) and 11 (held high). Code 10 returns to 00 on the next edge.
- R3: With the input-aware detector (USE_MEALY=1), each rise gives exactly one pulse, one cycle wide. It is visible after the second rising edge that follows the raw change, one cycle ahead of R2.
- R4: A falling edge, or a level that stays high, gives no pulse in either variant.
- R5: A raw high that lasts a single clock cycle gives exactly one pulse in each variant.
- R6: A level that is already high when reset is released gives exactly one pulse.
- R7: A raw input that toggles every cycle gives one pulse for every rise, with no rise lost or merged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| level_in | input | 1 | Raw asynchronous level |
| pulse_out | output | 1 | One-cycle pulse per synchronized rise |

## Verification
A detector state that is stuck or wrongly encoded shows up at the pulse output within one cycle of the next synchronized rise. It appears as a missing pulse, a pulse two cycles wide, or a pulse on a fall. A synchronizer with the wrong length moves the first pulse one cycle early or late, so the bench measures the latency in cycles from the raw change for each variant. The toggling pattern and the single-cycle pattern expose a detector that merges neighbouring rises or ignores a short high.

// File: rtl/rise_pulse_pkg.sv
// Package: shared encodings for the rising-edge pulse generator.
// Assumes: the state-only detector uses a two-bit register with one spare code.
package rise_pulse_pkg;

    typedef enum logic [1:0] {
        DET_IDLE = 2'b00,   // level low, waiting for a rise
        DET_SEEN = 2'b01,   // rise just seen, pulse cycle
        DET_HELD = 2'b11    // level high, waiting for the fall
    } det_state_e;

    // Spare code, never entered on purpose
    localparam logic [1:0] DET_SPARE = 2'b10;

endpackage

// File: rtl/rise_pulse_sync.sv
// Module: rise_pulse_sync
// Purpose: carries an asynchronous level into the clock domain through
//          STAGES back-to-back flops; only the last flop is used downstream.
// Assumes: STAGES >= 2; synchronous active-low reset clears every stage.
module rise_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    // Shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[LAST-1:0], async_in};
        end
    end

    assign sync_out = chain[LAST];

endmodule

// File: rtl/rise_pulse_moore.sv
// Module: rise_pulse_moore
// Purpose: state-only rising-edge detector with three encoded states;
//          the pulse is decoded from the state register alone.
// Assumes: lvl is already synchronized; spare code 10 recovers to idle.
module rise_pulse_moore
    import rise_pulse_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    output logic       pulse,
    output logic [1:0] state_q
);
    logic [1:0] state_d;

    // Minimized next-state equations, with the spare code forced to idle
    always_comb begin
        if (state_q == DET_SPARE) begin
            state_d = DET_IDLE;
        end else begin
            state_d = {lvl & state_q[0], lvl};
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DET_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pulse only in the rise-seen state
    assign pulse = ~state_q[1] & state_q[0];

endmodule

// File: rtl/rise_pulse_mealy.sv
// Module: rise_pulse_mealy
// Purpose: input-aware rising-edge detector; one bit remembers the previous
//          synchronized level and the pulse depends on it and the level.
// Assumes: lvl comes from a flop, so the combinational output cannot glitch
//          from an asynchronous source.
module rise_pulse_mealy (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse,
    output logic prev_q
);
    // Remember last cycle's synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    // High while the level is up and was down last cycle
    assign pulse = lvl & ~prev_q;

endmodule

// File: rtl/rise_pulse_unit.sv
// Module: rise_pulse_unit (top)
// Purpose: synchronizes a raw level and emits one pulse per rise, using the
//          detector that USE_MEALY selects.
// Assumes: SYNC_STAGES >= 2; synchronous active-low reset.
module rise_pulse_unit #(
    parameter bit USE_MEALY   = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic pulse_out
);
    logic       sync_lvl;
    logic [1:0] state_bits;

    rise_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (level_in),
        .sync_out (sync_lvl)
    );

    // Pick the detector variant at elaboration time
    generate
        if (USE_MEALY) begin : g_mealy
            logic prev_bit;
            rise_pulse_mealy u_det (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl    (sync_lvl),
                .pulse  (pulse_out),
                .prev_q (prev_bit)
            );
            assign state_bits = {1'b0, prev_bit};
        end else begin : g_moore
            rise_pulse_moore u_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .lvl     (sync_lvl),
                .pulse   (pulse_out),
                .state_q (state_bits)
            );
        end
    endgenerate

endmodule

// File: rtl/rise_pulse_chk.sv
// Module: rise_pulse_chk
// Purpose: temporal checks on the pulse generator, bound into every instance.
// Assumes: reset is held for at least three cycles at start.
module rise_pulse_chk #(
    parameter bit USE_MEALY   = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_lvl,
    input logic       pulse_out,
    input logic [1:0] state_bits
);
    initial begin
        assert_sync_depth_R2: assert (SYNC_STAGES >= 2);
    end

    // R1: reset silences the output on the next edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !pulse_out);

    // R2/R3: a pulse never lasts two cycles
    assert_single_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !pulse_out);

    generate
        if (USE_MEALY) begin : g_mealy_chk
            // R3: pulse in the same cycle the synchronized level rises
            assert_early_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sync_lvl) |-> pulse_out);
            // R4: pulse only on a fresh synchronized rise
            assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_out |-> (sync_lvl && !$past(sync_lvl)));
        end else begin : g_moore_chk
            // R2: pulse one cycle after the synchronized rise
            assert_late_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sync_lvl) |=> pulse_out);
            // R4: pulse only after a rise seen one cycle earlier
            assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_out |-> ($past(sync_lvl) && !$past(sync_lvl, 2)));
            // R2: spare code never held
            assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
                state_bits != 2'b10);
        end
    endgenerate

endmodule

bind rise_pulse_unit rise_pulse_chk #(
    .USE_MEALY   (USE_MEALY),
    .SYNC_STAGES (SYNC_STAGES)
) u_rise_pulse_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_lvl   (sync_lvl),
    .pulse_out  (pulse_out),
    .state_bits (state_bits)
);

// File: tb/test_rise_pulse_unit.sv
// Directed bench: both variants share clock, reset and raw input.
module test_rise_pulse_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic level_raw = 1'b0;
    logic pulse_moore;
    logic pulse_mealy;

    int n_checks = 0;
    int n_errors = 0;
    int rel = 0;
    int cnt_moore = 0;
    int cnt_mealy = 0;
    int first_moore = -1;
    int first_mealy = -1;
    int wide_moore = 0;
    int wide_mealy = 0;
    logic last_moore = 1'b0;
    logic last_mealy = 1'b0;

    always #5 clk = ~clk;

    rise_pulse_unit #(.USE_MEALY(1'b0)) i_rise_pulse_unit (
        .clk (clk), .rst_n (rst_n), .level_in (level_raw), .pulse_out (pulse_moore)
    );

    rise_pulse_unit #(.USE_MEALY(1'b1)) i_rise_pulse_unit_mealy (
        .clk (clk), .rst_n (rst_n), .level_in (level_raw), .pulse_out (pulse_mealy)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        rel = 0; cnt_moore = 0; cnt_mealy = 0;
        first_moore = -1; first_mealy = -1;
        wide_moore = 0; wide_mealy = 0;
        last_moore = 1'b0; last_mealy = 1'b0;
    endtask

    // One cycle: drive at the falling edge, then record the settled outputs
    task automatic tick(input logic lv);
        @(negedge clk);
        level_raw = lv;
        if (pulse_moore) begin
            if (first_moore < 0) first_moore = rel;
            cnt_moore++;
            if (last_moore) wide_moore++;
        end
        if (pulse_mealy) begin
            if (first_mealy < 0) first_mealy = rel;
            cnt_mealy++;
            if (last_mealy) wide_mealy++;
        end
        last_moore = pulse_moore;
        last_mealy = pulse_mealy;
        rel++;
    endtask

    task automatic settle_low();
        for (int i = 0; i < 5; i++) tick(1'b0);
        clear_obs();
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        tick(1'b0);
        clear_obs();
        for (int i = 0; i < 4; i++) tick(1'b0);
        check("R1", cnt_moore, 0, "state-only pulses in reset");
        check("R1", cnt_mealy, 0, "input-aware pulses in reset");
        @(negedge clk);
        rst_n = 1'b1;
        settle_low();
    endtask

    task automatic test_long_high();
        tick(1'b1);
        for (int i = 0; i < 19; i++) tick(1'b1);
        check("R2", cnt_moore, 1, "state-only pulses for long high");
        check("R2", first_moore, 3, "state-only latency");
        check("R2", wide_moore, 0, "state-only pulse wider than one cycle");
        check("R3", cnt_mealy, 1, "input-aware pulses for long high");
        check("R3", first_mealy, 2, "input-aware latency");
        check("R3", wide_mealy, 0, "input-aware pulse wider than one cycle");
        clear_obs();
        for (int i = 0; i < 10; i++) tick(1'b0);
        check("R4", cnt_moore, 0, "state-only pulses on fall");
        check("R4", cnt_mealy, 0, "input-aware pulses on fall");
        settle_low();
    endtask

    task automatic test_short_high();
        tick(1'b1);
        for (int i = 0; i < 10; i++) tick(1'b0);
        check("R5", cnt_moore, 1, "state-only pulses for one-cycle high");
        check("R5", cnt_mealy, 1, "input-aware pulses for one-cycle high");
        settle_low();
    endtask

    task automatic test_toggle();
        for (int i = 0; i < 5; i++) begin
            tick(1'b1);
            tick(1'b0);
        end
        for (int i = 0; i < 6; i++) tick(1'b0);
        check("R7", cnt_moore, 5, "state-only pulses for toggling input");
        check("R7", cnt_mealy, 5, "input-aware pulses for toggling input");
        check("R7", wide_moore + wide_mealy, 0, "merged pulses for toggling input");
        settle_low();
    endtask

    task automatic test_high_at_reset();
        rst_n = 1'b0;
        tick(1'b1);
        for (int i = 0; i < 3; i++) tick(1'b1);
        clear_obs();
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) tick(1'b1);
        check("R6", cnt_moore, 1, "state-only pulses when high at reset release");
        check("R6", cnt_mealy, 1, "input-aware pulses when high at reset release");
        settle_low();
    endtask

    initial begin
        test_reset();
        test_long_high();
        test_short_high();
        test_toggle();
        test_high_at_reset();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule